// File: doc/BRIEF.md
# Toggle-Requested Word Memory with Demonstration Sequencer

This block holds a small array of 32-bit words behind a single access port and keeps every touch of that array inside one procedural block, so that synthesis maps it onto a RAM rather than onto a bank of flip-flops. A state-machine datapath never indexes the array itself. It places a byte address, a store/load select and the store data on the port, then asks for an access by inverting a request flag. The memory wrapper keeps its own copy of that flag. When the flag and the copy differ it performs exactly one access on the next falling clock edge, and then brings the copy back into line with the flag.

A sequencer built into the block exercises the port. On a start pulse it writes the values 0 to COUNT-1 to consecutive word locations beginning at BASE_WORD, at one store per cycle. It then reads them back. Each load is followed by a wait state before the returned word is used. Every returned word is presented on the load outputs for one cycle. When the last word has been read the block raises a done flag and shows the sum of the words it read.

Top module: `flipreq_ram`

## Requirements
- R1: While reset is high at a rising edge, and in the cycle after it is released, done, busy, ld_valid, sum and ld_word are all 0, and no memory access takes place until start is seen.
- R2: The sequencer issues byte addresses whose two low bits are 0. The wrapper uses the byte address shifted right by two as the word index. Word i of a run is stored at and loaded from word index BASE_WORD+i.
- R3: A request is marked by a change in the level of the request flag, not by its level. Every change is served by exactly one access, and a flag that is held at either level causes no access.
- R4: The access requested at a rising edge is performed on the falling edge that follows it. A load's result is in the load-data register before the next rising edge.
- R5: Stores run at one per cycle with no extra state. Each load takes two cycles (issue, then wait), so two ld_valid pulses never occur in adjacent cycles. done becomes visible exactly 3*COUNT rising edges after the edge that accepts start.
- R6: ld_word changes only when a load is performed. Stores and idle cycles leave it holding the last loaded word.
- R7: For the i-th load of a run (counting from 0), ld_valid is high for one cycle with ld_index = i and ld_word = i, which is the value stored at word BASE_WORD+i.
- R8: done rises together with the last ld_valid of a run, at which point busy is low. sum then equals COUNT*(COUNT-1)/2, and done and sum hold until the next accepted start.
- R9: start is ignored while busy is high. A start accepted while idle, including after a completed run, begins a new run and clears done and sum at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The sequencer acts on rising edges and the memory acts on falling edges. |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a store/readback run when the block is idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed. Held until the next accepted start. |
| sum | output | DATA_W | Sum of the words loaded in the last run |
| ld_valid | output | 1 | One-cycle strobe for each returned word |
| ld_index | output | $clog2(COUNT) | Position of the returned word within the run |
| ld_word | output | DATA_W | Load-data register. Holds the last loaded word. |

## Verification
The bench builds the block with DEPTH=16, COUNT=8 and BASE_WORD=5. With this configuration it reads back every word of a run, and the non-zero base makes the shift from byte address to word index actually move data away from word 0. Eight words keep a full run down to 24 cycles, so the bench can run it twice. The second run checks that the load register holds still through the store phase, that a start pulse in the middle of the run is ignored, and that done and sum are cleared when the new run begins.

// File: rtl/frq_pkg.sv
package frq_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_STORE = 2'd1,
    CS_LOAD  = 2'd2,
    CS_LWAIT = 2'd3
  } ctl_state_t;

  // byte address -> word index (addresses are word aligned)
  function automatic int unsigned byte_to_word(input int unsigned byte_addr);
    return byte_addr >> 2;
  endfunction

  // word index -> byte address
  function automatic int unsigned word_to_byte(input int unsigned word_idx);
    return word_idx << 2;
  endfunction

endpackage

// File: rtl/frq_flagwatch.sv
// Detects a request as a difference between the flag and a local copy.
// The copy is refreshed on the falling edge that serves the request.
module frq_flagwatch (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  output logic req,
  output logic seen
);

  assign req = flag ^ seen;

  always_ff @(negedge clk) begin
    if (rst)      seen <= 1'b0;
    else if (req) seen <= flag;
  end

endmodule

// File: rtl/frq_wordram.sv
// Single-port word array. The array is touched from one block only.
module frq_wordram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int IW     = $clog2(DEPTH),
  parameter int AW     = IW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata,
  output logic              req,
  output logic              seen
);

  logic [IW-1:0]     widx;
  logic [DATA_W-1:0] mem [DEPTH];

  assign widx = IW'(frq_pkg::byte_to_word(int'(addr)));

  frq_flagwatch u_watch (
    .clk  (clk),
    .rst  (rst),
    .flag (flag),
    .req  (req),
    .seen (seen)
  );

  always_ff @(negedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (req) begin
      if (we) mem[widx] <= wdata;
      else    rdata     <= mem[widx];
    end
  end

endmodule

// File: rtl/frq_seqctl.sv
// Demonstration sequencer: stores 0..COUNT-1, then reads them back with a
// wait state after each load, accumulating the returned words.
module frq_seqctl #(
  parameter int DATA_W    = 32,
  parameter int AW        = 8,
  parameter int COUNT     = 16,
  parameter int BASE_WORD = 0,
  parameter int CW        = $clog2(COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] rdata,
  output logic [AW-1:0]     addr,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic              flag,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sum,
  output logic              ld_valid,
  output logic [CW-1:0]     ld_index,
  output logic              st_issue,
  output logic              ld_issue
);

  import frq_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  ctl_state_t    state;
  logic [CW-1:0] idx;

  function automatic logic [AW-1:0] addr_of(input logic [CW-1:0] i);
    return AW'(word_to_byte(BASE_WORD + int'(i)));
  endfunction

  assign busy     = (state != CS_IDLE);
  assign st_issue = (state == CS_STORE);
  assign ld_issue = (state == CS_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CS_IDLE;
      idx      <= '0;
      addr     <= '0;
      we       <= 1'b0;
      wdata    <= '0;
      flag     <= 1'b0;
      done     <= 1'b0;
      sum      <= '0;
      ld_valid <= 1'b0;
      ld_index <= '0;
    end else begin
      ld_valid <= 1'b0;
      unique case (state)
        CS_IDLE: begin
          if (start) begin
            state <= CS_STORE;
            idx   <= '0;
            sum   <= '0;
            done  <= 1'b0;
          end
        end
        CS_STORE: begin
          addr  <= addr_of(idx);
          we    <= 1'b1;
          wdata <= DATA_W'(idx);
          flag  <= ~flag;
          if (idx == LAST) begin
            idx   <= '0;
            state <= CS_LOAD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        CS_LOAD: begin
          addr  <= addr_of(idx);
          we    <= 1'b0;
          flag  <= ~flag;
          state <= CS_LWAIT;
        end
        CS_LWAIT: begin
          sum      <= sum + rdata;
          ld_valid <= 1'b1;
          ld_index <= idx;
          if (idx == LAST) begin
            idx   <= '0;
            done  <= 1'b1;
            state <= CS_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= CS_LOAD;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flipreq_ram.sv
module flipreq_ram #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter int COUNT     = 16,
  parameter int BASE_WORD = 0,
  parameter int IW_P      = $clog2(DEPTH),
  parameter int CW_P      = $clog2(COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sum,
  output logic              ld_valid,
  output logic [CW_P-1:0]   ld_index,
  output logic [DATA_W-1:0] ld_word
);

  localparam int IW = IW_P;
  localparam int AW = IW + 2;
  localparam int CW = CW_P;

  logic [AW-1:0]     ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;
  logic              ram_flag;
  logic              ram_req;
  logic              ram_seen;
  logic              st_issue;
  logic              ld_issue;

  frq_seqctl #(
    .DATA_W    (DATA_W),
    .AW        (AW),
    .COUNT     (COUNT),
    .BASE_WORD (BASE_WORD),
    .CW        (CW)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rdata    (ld_word),
    .addr     (ram_addr),
    .we       (ram_we),
    .wdata    (ram_wdata),
    .flag     (ram_flag),
    .busy     (busy),
    .done     (done),
    .sum      (sum),
    .ld_valid (ld_valid),
    .ld_index (ld_index),
    .st_issue (st_issue),
    .ld_issue (ld_issue)
  );

  frq_wordram #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IW     (IW),
    .AW     (AW)
  ) u_ram (
    .clk   (clk),
    .rst   (rst),
    .addr  (ram_addr),
    .we    (ram_we),
    .wdata (ram_wdata),
    .flag  (ram_flag),
    .rdata (ld_word),
    .req   (ram_req),
    .seen  (ram_seen)
  );

endmodule

// File: rtl/flipreq_ram_chk.sv
module flipreq_ram_chk #(
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              seen,
  input logic              flag,
  input logic              we,
  input logic [AW-1:0]     addr,
  input logic [DATA_W-1:0] rdata,
  input logic              ld_valid,
  input logic              done,
  input logic              busy
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !ld_valid && !busy && rdata == '0));

  // R2
  addr_align_chk: assert property (@(negedge clk) disable iff (rst)
    req |-> (addr[1:0] == 2'b00));

  // R3
  req_on_change_chk: assert property (@(negedge clk) disable iff (rst)
    req == (flag != $past(flag)));

  // R4
  flag_caught_chk: assert property (@(posedge clk) disable iff (rst)
    seen == flag);

  // R5
  wait_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !ld_valid);

  // R6
  rdata_hold_chk: assert property (@(negedge clk) disable iff (rst)
    !(req && !we) |=> $stable(rdata));

  // R8
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ld_valid);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind flipreq_ram flipreq_ram_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (ram_req),
  .seen     (ram_seen),
  .flag     (ram_flag),
  .we       (ram_we),
  .addr     (ram_addr),
  .rdata    (ld_word),
  .ld_valid (ld_valid),
  .done     (done),
  .busy     (busy)
);

// File: tb/flipreq_ram_tb.sv
module flipreq_ram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int DEPTH      = 16;
  localparam int COUNT      = 8;
  localparam int BASE_WORD  = 5;
  localparam int CW         = $clog2(COUNT);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              busy;
  logic              done;
  logic [DATA_W-1:0] sum;
  logic              ld_valid;
  logic [CW-1:0]     ld_index;
  logic [DATA_W-1:0] ld_word;

  int total = 0;
  int bad = 0;
  int loads_seen = 0;
  bit prev_valid = 1'b0;
  int ref_words [COUNT];
  int exp_sum = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flipreq_ram #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .COUNT     (COUNT),
    .BASE_WORD (BASE_WORD)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .sum      (sum),
    .ld_valid (ld_valid),
    .ld_index (ld_index),
    .ld_word  (ld_word)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one rising edge, then sample away from it; load strobes checked here
  task automatic step();
    @(posedge clk);
    #2;
    if (ld_valid) begin
      // R7 / R2: word i read back from word BASE_WORD+i is the value i
      check(int'(ld_word) == ref_words[loads_seen % COUNT], "R7 ld_word",
            ld_word, ref_words[loads_seen % COUNT]);
      check(int'(ld_index) == loads_seen, "R7 ld_index", ld_index, loads_seen);
      // R5: a wait state separates loads
      check(!prev_valid, "R5 load gap", prev_valid, 0);
      loads_seen++;
    end
    prev_valid = ld_valid;
  endtask

  task automatic run(input bit second);
    int k;
    loads_seen = 0;
    start = 1'b1;
    step();
    start = 1'b0;
    // R9: accepting edge clears done and sum
    check(done == 1'b0, "R9 done cleared", done, 0);
    check(sum == '0, "R9 sum cleared", sum, 0);
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    k = 0;
    while (!done && k < 1000) begin
      // R9: start pulse in mid-run must be ignored
      start = (second && k == COUNT + 3);
      step();
      k++;
      // R6: during the store phase the load register keeps the old word
      if (second && k <= COUNT)
        check(int'(ld_word) == ref_words[COUNT-1], "R6 hold in stores",
              ld_word, ref_words[COUNT-1]);
    end
    start = 1'b0;
    check(k == 3 * COUNT, "R5 run length", k, 3 * COUNT);
    check(loads_seen == COUNT, "R3 one access per toggle (load count)", loads_seen, COUNT);
    check(int'(sum) == exp_sum, "R8 sum", sum, exp_sum);
    check(busy == 1'b0, "R8 idle at done", busy, 0);
    repeat (3) step();
    check(done == 1'b1, "R8 done held", done, 1);
    check(int'(sum) == exp_sum, "R8 sum held", sum, exp_sum);
    check(int'(ld_word) == ref_words[COUNT-1], "R6 hold when idle",
          ld_word, ref_words[COUNT-1]);
    check(loads_seen == COUNT, "R9 no restart when idle", loads_seen, COUNT);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < COUNT; i++) begin
      ref_words[i] = i;
      exp_sum += i;
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1: state during reset
    check(done == 1'b0, "R1 done", done, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(ld_valid == 1'b0, "R1 ld_valid", ld_valid, 0);
    check(sum == '0, "R1 sum", sum, 0);
    check(ld_word == '0, "R1 ld_word", ld_word, 0);
    rst = 1'b0;
    // R1 / R3: no spurious access with the flag held
    repeat (5) step();
    check(loads_seen == 0 && !busy, "R1 quiet after reset", loads_seen, 0);
    check(ld_word == '0, "R3 no access while flag steady", ld_word, 0);

    run(1'b0);
    run(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule